// File: doc/BRIEF.md
# Double-Buffered Byte-Sequenced Converter Code Loader

This block is the digital front end of a 12-bit converter. A host writes a code over an 8-bit bus in up to two write cycles. A high-byte cycle is marked by the byte-select line being high. It stores the whole bus as code bits 11..4. In the same cycle it also stores bus lines 7..4 as code bits 3..0. A following low-nibble cycle, marked by the byte-select line being low, overwrites only bits 3..0, again taken from bus lines 7..4. A host that needs only eight bits of resolution can therefore skip the second cycle.

The two holding registers, 8 bits and 4 bits wide, are double-buffered behind a 12-bit output register that drives the converter. A transfer strobe, qualified by its own write strobe, copies both holding registers into the output register at once. Chip select does not take part in the transfer. While chip select is high, activity on the bus and on write-1 changes nothing inside the block. All strobes are active low.

All control inputs and the bus pass through a two-stage synchronizer on the system clock. Each register then loads on every clock in which its qualified enable is active, so a held strobe behaves like a transparent latch at clock resolution.

Top module: `dac_byte_loader`

## Requirements
- R1: The active-low asynchronous reset clears the 8-bit holding register, the 4-bit holding register and the output register to zero. After reset, code_o is 0x000, and a transfer with no prior write also gives 0x000.
- R2: When the synchronized byte_hi_i=1, cs_ni=0 and wr1_ni=0, bus_i[7:0] loads code bits 11..4 and bus_i[7:4] loads code bits 3..0.
- R3: When the synchronized byte_hi_i=0, cs_ni=0 and wr1_ni=0, only code bits 3..0 load, from bus_i[7:4]. Bits 11..4 keep their value.
- R4: When the synchronized xfer_ni=0 and wr2_ni=0, the output register takes {bits 11..4, bits 3..0} from the holding registers, whatever the level of cs_ni.
- R5: Writes to the holding registers leave code_o unchanged until a transfer occurs.
- R6: While cs_ni=1, toggling bus_i, byte_hi_i and wr1_ni changes no holding register.
- R7: While cs_ni=0 and wr1_ni=1, no holding register loads.
- R8: No transfer occurs when only one of xfer_ni and wr2_ni is low.
- R9: When a write and a transfer are active in the same clock, the output register takes the holding-register values from before that write. The new data reaches code_o on a later transfer.
- R10: Repeated transfers with no write in between leave code_o at the same value.
- R11: A strobe level applied before clock edge k takes effect on code_o or a holding register at edge k+2. code_o therefore changes three edges after the transfer strobes are driven low: two synchronizer stages and one register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, gates write-1 |
| wr1_ni | input | 1 | Write strobe for the holding registers, active low |
| wr2_ni | input | 1 | Write strobe that gates the transfer, active low |
| xfer_ni | input | 1 | Transfer strobe, active low |
| byte_hi_i | input | 1 | 1 selects the high-byte cycle, 0 selects the low-nibble cycle |
| bus_i | input | 8 | Data bus |
| code_o | output | 12 | Converter code, bit 11 is the MSB |

## Verification
A strobe driven just after a falling edge passes the two synchronizer stages on the next two rising edges. The targeted register loads on the third rising edge, so code_o is due three edges after the transfer strobes are driven. The bench drives every input on a falling edge and checks the latency directly: code_o must still hold the old value after two edges and the new value after three. Every other check waits at least four cycles after all strobes are released before it samples on a falling edge, so no result depends on edge ordering.

// File: rtl/dac_byte_loader_pkg.sv
package dac_byte_loader_pkg;
  localparam int unsigned CODE_W_DEF = 12;
  localparam int unsigned BUS_W_DEF  = 8;
  localparam int unsigned SYNC_DEF   = 2;

  typedef struct packed {
    logic byte_hi;
    logic cs_n;
    logic wr1_n;
    logic wr2_n;
    logic xfer_n;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam ctrl_t CTRL_IDLE = '{byte_hi: 1'b0, cs_n: 1'b1, wr1_n: 1'b1,
                                   wr2_n: 1'b1, xfer_n: 1'b1};
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dac_hold_reg.sv
module dac_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/dac_byte_loader.sv
module dac_byte_loader
  import dac_byte_loader_pkg::*;
#(
  parameter int unsigned CODE_W = CODE_W_DEF,
  parameter int unsigned BUS_W  = BUS_W_DEF,
  parameter int unsigned SYNC   = SYNC_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr1_ni,
  input  logic              wr2_ni,
  input  logic              xfer_ni,
  input  logic              byte_hi_i,
  input  logic [BUS_W-1:0]  bus_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned LO_W   = CODE_W - BUS_W;
  localparam int unsigned SYNC_W = CTRL_W + BUS_W;

  ctrl_t             ctrl_raw, ctrl_s;
  logic [BUS_W-1:0]  bus_s;
  logic [BUS_W-1:0]  hi_q;
  logic [LO_W-1:0]   lo_q;
  logic              hi_en, lo_en, xfer_en;

  assign ctrl_raw = '{byte_hi: byte_hi_i, cs_n: cs_ni, wr1_n: wr1_ni,
                      wr2_n: wr2_ni, xfer_n: xfer_ni};

  // control and bus share one synchronizer so they stay aligned
  dac_sync #(
    .W(SYNC_W), .STAGES(SYNC), .RST_VAL({CTRL_IDLE, {BUS_W{1'b0}}})
  ) u_sync (
    .clk_i, .rst_ni,
    .d_i({ctrl_raw, bus_i}),
    .q_o({ctrl_s, bus_s})
  );

  assign lo_en   = !ctrl_s.cs_n && !ctrl_s.wr1_n;
  assign hi_en   = lo_en && ctrl_s.byte_hi;
  assign xfer_en = !ctrl_s.xfer_n && !ctrl_s.wr2_n;

  dac_hold_reg #(.W(BUS_W)) u_hi (
    .clk_i, .rst_ni, .en_i(hi_en), .d_i(bus_s), .q_o(hi_q)
  );

  // low nibble always comes from the top bus lines
  dac_hold_reg #(.W(LO_W)) u_lo (
    .clk_i, .rst_ni, .en_i(lo_en), .d_i(bus_s[BUS_W-1 -: LO_W]), .q_o(lo_q)
  );

  dac_hold_reg #(.W(CODE_W)) u_out (
    .clk_i, .rst_ni, .en_i(xfer_en), .d_i({hi_q, lo_q}), .q_o(code_o)
  );
endmodule

// File: rtl/dac_byte_loader_chk.sv
module dac_byte_loader_chk #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned BUS_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_s,
  input logic              wr1_s,
  input logic              byte_hi_s,
  input logic              xfer_s,
  input logic              wr2_s,
  input logic [BUS_W-1:0]  bus_s,
  input logic [BUS_W-1:0]  hi_q,
  input logic [CODE_W-BUS_W-1:0] lo_q,
  input logic [CODE_W-1:0] code_o
);
  localparam int unsigned LO_W = CODE_W - BUS_W;

  // R2
  hi_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_s && !wr1_s && byte_hi_s) |=> (hi_q == $past(bus_s)));

  // R3
  lo_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_s && !wr1_s) |=> (lo_q == $past(bus_s[BUS_W-1 -: LO_W])));

  // R3
  lo_keeps_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_s && !wr1_s && !byte_hi_s) |=> $stable(hi_q));

  // R6
  cs_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> ($stable(hi_q) && $stable(lo_q)));

  // R7
  wr1_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr1_s |=> ($stable(hi_q) && $stable(lo_q)));

  // R4
  xfer_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_s && !wr2_s) |=> (code_o == $past({hi_q, lo_q})));

  // R8
  xfer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_s || wr2_s) |=> $stable(code_o));
endmodule

bind dac_byte_loader dac_byte_loader_chk #(.CODE_W(CODE_W), .BUS_W(BUS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .cs_s(ctrl_s.cs_n), .wr1_s(ctrl_s.wr1_n), .byte_hi_s(ctrl_s.byte_hi),
  .xfer_s(ctrl_s.xfer_n), .wr2_s(ctrl_s.wr2_n), .bus_s(bus_s),
  .hi_q(hi_q), .lo_q(lo_q), .code_o(code_o)
);

// File: tb/dac_byte_loader_bench.sv
`timescale 1ns/1ps
module dac_byte_loader_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, wr1_ni = 1'b1, wr2_ni = 1'b1, xfer_ni = 1'b1;
  logic byte_hi_i = 1'b0;
  logic [7:0]  bus_i = 8'h00;
  logic [11:0] code_o;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dac_byte_loader u_dac_byte_loader (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .wr1_ni(wr1_ni),
    .wr2_ni(wr2_ni), .xfer_ni(xfer_ni), .byte_hi_i(byte_hi_i),
    .bus_i(bus_i), .code_o(code_o)
  );

  // op: 0 high-byte write, 1 low-nibble write, 2 transfer (cs high), 3 write with cs high
  localparam int NV = 11;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 8'hA5, 12'h000},
    {2'd2, 8'h00, 12'hA5A},
    {2'd1, 8'h3C, 12'hA5A},
    {2'd2, 8'h00, 12'hA53},
    {2'd2, 8'h00, 12'hA53},
    {2'd3, 8'hF0, 12'hA53},
    {2'd2, 8'h00, 12'hA53},
    {2'd1, 8'h70, 12'hA53},
    {2'd2, 8'h00, 12'hA57},
    {2'd0, 8'h12, 12'hA57},
    {2'd2, 8'h00, 12'h121}
  };

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cs_ni = 1'b1; wr1_ni = 1'b1; wr2_ni = 1'b1; xfer_ni = 1'b1; byte_hi_i = 1'b0;
  endtask

  task automatic apply_op(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    bus_i = d;
    case (op)
      2'd0: begin cs_ni = 1'b0; wr1_ni = 1'b0; byte_hi_i = 1'b1; end
      2'd1: begin cs_ni = 1'b0; wr1_ni = 1'b0; byte_hi_i = 1'b0; end
      2'd2: begin cs_ni = 1'b1; wr2_ni = 1'b0; xfer_ni = 1'b0; end
      default: begin cs_ni = 1'b1; wr1_ni = 1'b0; byte_hi_i = 1'b1; end
    endcase
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (op == 2'd3) begin bus_i = ~bus_i; byte_hi_i = ~byte_hi_i; end
    end
    idle();
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", code_o, 12'h000);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5 R6 R10 via table
    for (int v = 0; v < NV; v++) begin
      apply_op(VEC[v][21:20], VEC[v][19:12]);
      check($sformatf("R2/R3/R4/R5/R6/R10 vector %0d", v), code_o, VEC[v][11:0]);
    end

    // R7: cs low, wr1 high
    @(negedge clk);
    cs_ni = 1'b0; byte_hi_i = 1'b1; bus_i = 8'h5E;
    repeat (4) @(negedge clk);
    idle();
    apply_op(2'd2, 8'h00);
    check("R7 wr1 high ignored", code_o, 12'h121);

    // R8: single transfer qualifier
    apply_op(2'd0, 8'hC3);
    @(negedge clk); xfer_ni = 1'b0;
    repeat (4) @(negedge clk); idle();
    repeat (4) @(negedge clk);
    check("R8 xfer only", code_o, 12'h121);
    @(negedge clk); wr2_ni = 1'b0;
    repeat (4) @(negedge clk); idle();
    repeat (4) @(negedge clk);
    check("R8 wr2 only", code_o, 12'h121);

    // R11 latency: expect C3C three edges after strobes
    @(negedge clk); wr2_ni = 1'b0; xfer_ni = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 not yet after two edges", code_o, 12'h121);
    @(negedge clk);
    check("R11 due after three edges", code_o, 12'hC3C);
    idle();
    repeat (4) @(negedge clk);

    // R9: write and transfer in the same clock
    apply_op(2'd1, 8'h90);
    @(negedge clk);
    cs_ni = 1'b0; wr1_ni = 1'b0; byte_hi_i = 1'b1; bus_i = 8'hEF;
    wr2_ni = 1'b0; xfer_ni = 1'b0;
    @(negedge clk);
    idle();
    repeat (4) @(negedge clk);
    check("R9 pre-write values transferred", code_o, 12'hC39);
    apply_op(2'd2, 8'h00);
    check("R9 new data on later transfer", code_o, 12'hEFE);

    // R1: mid-run reset clears holding registers too
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    check("R1 reset clears output", code_o, 12'h000);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    apply_op(2'd2, 8'h00);
    check("R1 reset clears holding registers", code_o, 12'h000);

    summary();
    $finish;
  end
endmodule